// File: doc/BRIEF.md
# Supply-Level Calibration Programming Sequencer

This block lets a timekeeping calibration word be written into non-volatile cells using nothing but the supply pin. Three pre-decoded level flags report whether the supply sits near the high programming level (about 5.1 V), the mid level (about 4.5 V) or the low level (about 2.5 V). No flag set means the ordinary operating level. A fourth input reports whether a motor drive pulse is in progress. Each level flag passes through a persistence filter before the state machine acts on it. The machine then recognises the entry gesture, strobes an erase, forms the value n by counting supply dips, strobes a store and returns to normal operation.

States and transitions:
- `ST_IDLE` (normal operation) goes to `ST_READBACK` when the level becomes high.
- `ST_READBACK` enables readback of the stored value. A move to low while the motor flag is set goes to `ST_ARMED`. Any other move to low or to the operating level goes back to `ST_IDLE`.
- `ST_ARMED` goes to `ST_ERASE` on the next rise to high, or straight to `ST_COUNT` once the write budget is spent.
- `ST_ERASE` lasts one cycle and always moves on to `ST_COUNT`.
- `ST_COUNT` increments n on every high-to-mid dip and goes to `ST_LOADED` when the level reaches low.
- `ST_LOADED` goes to `ST_STORE` on a rise to high, or to `ST_STORED` when the budget is spent.
- `ST_STORE` lasts one cycle and always moves on to `ST_STORED`.
- `ST_STORED` goes to `ST_IDLE` on a move to low or to the operating level.
- From `ST_ARMED`, `ST_COUNT` and `ST_LOADED`, a fall to the operating level aborts to `ST_IDLE`.

The stored word is presented on `cal_value` and only changes with a store strobe. `write_count` records how many stores have been made and stops at the reprogramming limit.

Top module: `supply_cal_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, erase_pulse, store_pulse, readback_en and test_flag are 0, and cal_value and write_count are 0.
- R2: A level flag must hold a new value for STABLE_CYCLES (default 4) consecutive clock cycles before the machine reacts to it. A pulse on lvl_high lasting 2 cycles leaves readback_en at 0.
- R3: From idle, a settled rise to the high level sets readback_en to 1. A later fall to the operating level (no flag set) clears it.
- R4: A settled fall from readback to the low level while motor_active is 1 enters programming, and readback_en goes to 0. The same fall with motor_active at 0 returns to idle, and a following rise to high gives readback again and no erase.
- R5: The first rise to high after entry produces erase_pulse for exactly one cycle. test_flag is 1 from the cycle after the strobe until the sequence ends.
- R6: While counting, every transition from the high level to the mid level adds one to n. Returns from mid to high add nothing, and a fall to low ends counting.
- R7: n saturates at 63 (all ones in 6 bits). More dips leave it at 63.
- R8: The rise to high after counting produces store_pulse for exactly one cycle. cal_value takes the counted n in that same cycle, write_count increases by one, and cal_value is unchanged in every cycle without a store strobe.
- R9: A fall to low after the store ends the sequence: test_flag returns to 0 and a following rise to high gives readback again.
- R10: Once write_count has reached MAX_WRITES (default 100), further sequences produce neither erase_pulse nor store_pulse, and cal_value and write_count keep their values.
- R11: A fall to the operating level during entry, counting or loading abandons the sequence: test_flag goes to 0 and no store is made.
- R12: At most one of erase_pulse, store_pulse and readback_en is 1 in any cycle, and readback_en is never 1 together with test_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lvl_high | input | 1 | Supply near the high programming level |
| lvl_mid | input | 1 | Supply near the mid level |
| lvl_low | input | 1 | Supply near the low level |
| motor_active | input | 1 | Motor drive pulse in progress |
| erase_pulse | output | 1 | One-cycle erase command |
| store_pulse | output | 1 | One-cycle store command |
| cal_value | output | 6 | Calibration word n, valid with and after store_pulse |
| test_flag | output | 1 | Status: 1 after erase until the sequence ends |
| readback_en | output | 1 | Readback mode enable |
| write_count | output | 7 | Number of completed stores, capped at MAX_WRITES |

## Verification
The checker watches every cycle for several properties: that both strobes last one cycle, that the erase is followed by a raised test flag, that each store advances the write counter by exactly one, and that a store is never made past the limit. It also checks that the calibration word moves only with a store and that the three mode outputs never overlap. Other behaviours depend on whole supply gestures and can only be shown by the bench's scenarios: the rejection of short level glitches, the need for a motor pulse at entry, the exact dip count including saturation at 63, the abort on a fall to the operating level, and the silence of both strobes after the hundredth store.

// File: rtl/supply_cal_pkg.sv
package supply_cal_pkg;

    typedef enum logic [1:0] {
        LV_OPER = 2'd0,
        LV_LOW  = 2'd1,
        LV_MID  = 2'd2,
        LV_HIGH = 2'd3
    } level_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READBACK = 3'd1,
        ST_ARMED    = 3'd2,
        ST_ERASE    = 3'd3,
        ST_COUNT    = 3'd4,
        ST_LOADED   = 3'd5,
        ST_STORE    = 3'd6,
        ST_STORED   = 3'd7
    } seq_state_t;

    // High has priority over mid, mid over low; no flag is the operating level.
    function automatic level_t decode_level(input logic hi, input logic mid, input logic lo);
        if (hi)       return LV_HIGH;
        else if (mid) return LV_MID;
        else if (lo)  return LV_LOW;
        else          return LV_OPER;
    endfunction

endpackage

// File: rtl/supply_cal_filter.sv
module supply_cal_filter #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt    <= 1'b0;
            run_cnt <= '0;
        end else if (raw == filt) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            filt    <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/supply_cal_satcnt.sv
module supply_cal_satcnt #(
    parameter int WIDTH = 6,
    parameter int LIMIT = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] LIMIT_V = WIDTH'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && (count != LIMIT_V)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/supply_cal_sequencer.sv
module supply_cal_sequencer #(
    parameter int STABLE_CYCLES = 4,
    parameter int N_WIDTH       = 6,
    parameter int MAX_WRITES    = 100,
    parameter int WC_W          = $clog2(MAX_WRITES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lvl_high,
    input  logic               lvl_mid,
    input  logic               lvl_low,
    input  logic               motor_active,
    output logic               erase_pulse,
    output logic               store_pulse,
    output logic [N_WIDTH-1:0] cal_value,
    output logic               test_flag,
    output logic               readback_en,
    output logic [WC_W-1:0]    write_count
);
    import supply_cal_pkg::*;

    localparam int N_MAX     = (1 << N_WIDTH) - 1;
    localparam int N_FLAGS   = 3;
    localparam logic [WC_W-1:0] WC_LIMIT = WC_W'(MAX_WRITES);

    // Level persistence filters, one per supply flag
    logic [N_FLAGS-1:0] raw_flags;
    logic [N_FLAGS-1:0] flt_flags;

    assign raw_flags = {lvl_high, lvl_mid, lvl_low};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_filt
        supply_cal_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flags[g]),
            .filt (flt_flags[g])
        );
    end

    // Level events
    level_t cur_lvl;
    level_t prev_lvl;
    logic   lvl_chg;
    logic   dip_evt;

    assign cur_lvl = decode_level(flt_flags[2], flt_flags[1], flt_flags[0]);
    assign lvl_chg = (cur_lvl != prev_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= LV_OPER;
        else        prev_lvl <= cur_lvl;
    end

    // State register
    seq_state_t state;
    seq_state_t nxt;
    logic       exhausted;

    assign exhausted = (write_count == WC_LIMIT);
    assign dip_evt   = (state == ST_COUNT) && lvl_chg &&
                       (cur_lvl == LV_MID) && (prev_lvl == LV_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (lvl_chg && cur_lvl == LV_HIGH) nxt = ST_READBACK;
            end
            ST_READBACK: begin
                if (lvl_chg) begin
                    if (cur_lvl == LV_LOW && motor_active)            nxt = ST_ARMED;
                    else if (cur_lvl == LV_LOW || cur_lvl == LV_OPER) nxt = ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (lvl_chg) begin
                    if (cur_lvl == LV_HIGH)      nxt = exhausted ? ST_COUNT : ST_ERASE;
                    else if (cur_lvl == LV_OPER) nxt = ST_IDLE;
                end
            end
            ST_ERASE: nxt = ST_COUNT;
            ST_COUNT: begin
                if (lvl_chg) begin
                    if (cur_lvl == LV_LOW)       nxt = ST_LOADED;
                    else if (cur_lvl == LV_OPER) nxt = ST_IDLE;
                end
            end
            ST_LOADED: begin
                if (lvl_chg) begin
                    if (cur_lvl == LV_HIGH)      nxt = exhausted ? ST_STORED : ST_STORE;
                    else if (cur_lvl == LV_OPER) nxt = ST_IDLE;
                end
            end
            ST_STORE: nxt = ST_STORED;
            ST_STORED: begin
                if (lvl_chg && (cur_lvl == LV_LOW || cur_lvl == LV_OPER)) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Dip counter forming n, cleared while armed
    logic [N_WIDTH-1:0] dip_count;

    supply_cal_satcnt #(.WIDTH(N_WIDTH), .LIMIT(N_MAX)) u_dips (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state == ST_ARMED),
        .inc  (dip_evt),
        .count(dip_count)
    );

    // Completed-store counter
    supply_cal_satcnt #(.WIDTH(WC_W), .LIMIT(MAX_WRITES)) u_writes (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(1'b0),
        .inc  (state == ST_STORE),
        .count(write_count)
    );

    // Calibration word: loaded as the store state is entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cal_value <= '0;
        else if (nxt == ST_STORE)  cal_value <= dip_count;
    end

    // Outputs
    always_comb begin
        erase_pulse = 1'b0;
        store_pulse = 1'b0;
        readback_en = 1'b0;
        test_flag   = 1'b0;
        unique case (state)
            ST_READBACK: readback_en = 1'b1;
            ST_ERASE:    erase_pulse = 1'b1;
            ST_COUNT:    test_flag   = 1'b1;
            ST_LOADED:   test_flag   = 1'b1;
            ST_STORE: begin
                store_pulse = 1'b1;
                test_flag   = 1'b1;
            end
            ST_STORED:   test_flag   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/supply_cal_sequencer_chk.sv
module supply_cal_sequencer_chk #(
    parameter int N_WIDTH    = 6,
    parameter int MAX_WRITES = 100,
    parameter int WC_W       = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               erase_pulse,
    input logic               store_pulse,
    input logic [N_WIDTH-1:0] cal_value,
    input logic               test_flag,
    input logic               readback_en,
    input logic [WC_W-1:0]    write_count
);
    localparam logic [WC_W-1:0] WC_LIMIT = WC_W'(MAX_WRITES);

    assert_erase_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |=> !erase_pulse);

    assert_erase_raises_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |=> test_flag);

    assert_store_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> !store_pulse);

    assert_store_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> (write_count == $past(write_count) + 1'b1));

    assert_cal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !store_pulse |-> $stable(cal_value));

    assert_no_store_past_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> (write_count < WC_LIMIT));

    assert_count_capped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        write_count <= WC_LIMIT);

    assert_modes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_pulse, store_pulse, readback_en}));

    assert_readback_no_test_R12: assert property (@(posedge clk) disable iff (!rst_n)
        readback_en |-> !test_flag);
endmodule

bind supply_cal_sequencer supply_cal_sequencer_chk #(
    .N_WIDTH   (N_WIDTH),
    .MAX_WRITES(MAX_WRITES),
    .WC_W      (WC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_pulse(erase_pulse),
    .store_pulse(store_pulse),
    .cal_value  (cal_value),
    .test_flag  (test_flag),
    .readback_en(readback_en),
    .write_count(write_count)
);

// File: tb/supply_cal_sequencer_bench.sv
module supply_cal_sequencer_bench;

    localparam int STABLE = 4;
    localparam int HOLD   = STABLE + 4;
    localparam int MAXW   = 100;
    localparam int NVEC   = 6;
    localparam int DIPS [NVEC] = '{0, 1, 5, 63, 70, 2};
    localparam int EXPN [NVEC] = '{0, 1, 5, 63, 63, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl_high = 1'b0, lvl_mid = 1'b0, lvl_low = 1'b0, motor_active = 1'b0;
    logic       erase_pulse, store_pulse, test_flag, readback_en;
    logic [5:0] cal_value;
    logic [6:0] write_count;

    int tests = 0, fails = 0;
    int erase_seen = 0, store_seen = 0, width_err = 0, overlap_err = 0;
    logic erase_d = 1'b0, store_d = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supply_cal_sequencer #(.STABLE_CYCLES(STABLE), .MAX_WRITES(MAXW)) u_supply_cal_sequencer (
        .clk(clk), .rst_n(rst_n), .lvl_high(lvl_high), .lvl_mid(lvl_mid), .lvl_low(lvl_low),
        .motor_active(motor_active), .erase_pulse(erase_pulse), .store_pulse(store_pulse),
        .cal_value(cal_value), .test_flag(test_flag), .readback_en(readback_en),
        .write_count(write_count)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (erase_pulse) erase_seen++;
            if (store_pulse) store_seen++;
            if ((erase_pulse && erase_d) || (store_pulse && store_d)) width_err++;
            if ($countones({erase_pulse, store_pulse, readback_en}) > 1) overlap_err++;
            if (readback_en && test_flag) overlap_err++;
            erase_d = erase_pulse;
            store_d = store_pulse;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // 0 = operating, 1 = low, 2 = mid, 3 = high
    task automatic set_level(input int lv);
        @(negedge clk);
        lvl_high = (lv == 3);
        lvl_mid  = (lv == 2);
        lvl_low  = (lv == 1);
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic enter_and_erase();
        set_level(3);
        motor_active = 1'b1;
        set_level(1);
        motor_active = 1'b0;
        set_level(3);
    endtask

    task automatic program_n(input int n);
        enter_and_erase();
        for (int i = 0; i < n; i++) begin
            set_level(2);
            set_level(3);
        end
        set_level(1);
        set_level(3);
        set_level(1);
        set_level(0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int e0, s0, exp_wc;
        exp_wc = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!erase_pulse && !store_pulse && !readback_en && !test_flag, "R1 reset strobes", 0, 0);
        check(cal_value == 0 && write_count == 0, "R1 reset values", int'(cal_value) + int'(write_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!readback_en && !test_flag && write_count == 0, "R1 after reset", int'(readback_en), 0);

        // R2: short glitch on the high flag
        lvl_high = 1'b1;
        repeat (2) @(negedge clk);
        lvl_high = 1'b0;
        repeat (HOLD) @(negedge clk);
        check(readback_en == 1'b0, "R2 glitch ignored", int'(readback_en), 0);

        // R3: readback on and off
        set_level(3);
        check(readback_en == 1'b1, "R3 readback on", int'(readback_en), 1);
        set_level(0);
        check(readback_en == 1'b0, "R3 readback off", int'(readback_en), 0);

        // R4: low without motor pulse gives no entry
        set_level(3);
        set_level(1);
        check(readback_en == 1'b0 && test_flag == 1'b0, "R4 no entry idle", int'(test_flag), 0);
        e0 = erase_seen;
        set_level(3);
        check(readback_en == 1'b1, "R4 readback again", int'(readback_en), 1);
        check(erase_seen == e0, "R4 no erase", erase_seen - e0, 0);
        set_level(0);

        // R5 and R11: enter, erase, dips, then abort at operating level
        e0 = erase_seen;
        s0 = store_seen;
        set_level(3);
        motor_active = 1'b1;
        set_level(1);
        motor_active = 1'b0;
        check(readback_en == 1'b0, "R4 entry clears readback", int'(readback_en), 0);
        set_level(3);
        check(erase_seen == e0 + 1, "R5 one erase", erase_seen - e0, 1);
        check(test_flag == 1'b1, "R5 test flag set", int'(test_flag), 1);
        set_level(2);
        set_level(3);
        set_level(0);
        check(test_flag == 1'b0, "R11 abort clears test", int'(test_flag), 0);
        check(store_seen == s0 && write_count == 0, "R11 no store", store_seen - s0, 0);

        // R6, R7, R8, R9: vector table
        for (int v = 0; v < NVEC; v++) begin
            e0 = erase_seen;
            s0 = store_seen;
            program_n(DIPS[v]);
            exp_wc++;
            check(cal_value == 6'(EXPN[v]), "R6 R7 dip count", int'(cal_value), EXPN[v]);
            check(store_seen == s0 + 1 && erase_seen == e0 + 1, "R8 one store", store_seen - s0, 1);
            check(write_count == 7'(exp_wc), "R8 write count", int'(write_count), exp_wc);
            check(test_flag == 1'b0, "R9 sequence ended", int'(test_flag), 0);
        end

        // R9: readback after store
        set_level(3);
        check(readback_en == 1'b1, "R9 readback after store", int'(readback_en), 1);
        set_level(0);

        // R10: use up the write budget, then one more attempt
        while (exp_wc < MAXW) begin
            program_n(1);
            exp_wc++;
        end
        check(write_count == 7'(MAXW) && cal_value == 6'd1, "R10 budget reached", int'(write_count), MAXW);
        e0 = erase_seen;
        s0 = store_seen;
        program_n(9);
        check(erase_seen == e0 && store_seen == s0, "R10 strobes silent", erase_seen - e0 + store_seen - s0, 0);
        check(cal_value == 6'd1, "R10 value kept", int'(cal_value), 1);
        check(write_count == 7'(MAXW), "R10 count kept", int'(write_count), MAXW);

        // R5 R8 R12: strobe width and exclusivity over the whole run
        check(width_err == 0, "R5 R8 strobe width", width_err, 0);
        check(overlap_err == 0, "R12 modes exclusive", overlap_err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule